// File: doc/BRIEF.md
# One-Time-Programmable Fuse Command Controller

This block sits between a CPU register bus and a one-time-programmable fuse macro. Software loads a fuse address into one register, then writes a command word whose strobe bit starts an operation. The controller supports power-up, power-down, array read, margin read, single-bit program and a full refresh. While an operation runs, the controller drives the macro's sense and program pins and holds a busy flag. Read results land in a read-data register. A refresh walks every physical fuse row and fills a bank of read-only shadow registers. After a refresh the macro is powered down again without a separate command.

The fuse array holds twice as many physical rows as logical words. Each logical word w is stored redundantly in physical rows 2w and 2w+1, and the shadow copy is the OR of the two rows. A sticky lock register blocks further programming until reset. The register bus is a plain single-cycle select/write port. Writes take effect on the clock edge, and read data is combinational from the address. No valid/ready stream exists at this block's edge.

Top module: `efuse_ctrl`

## Requirements
- R1: After reset, status reads 0 (busy bit 0 and powered bit 1 clear), read data reads 0, the mode register reads 0 and every shadow word reads 0.
- R2: A write to offset 0x000 with bit 4 set launches an operation, provided the controller is idle. Power-up, power-down, array read, margin read and program each keep busy (status bit 0) high for exactly OP_CYCLES cycles. The mode register reads back the written bits [5:0] with bit 4 cleared.
- R3: While busy is high, every bus write is ignored. The mode register, the address register (0x004) and the lock register keep their values, and no new operation starts.
- R4: Command 0x10 powers the macro up and command 0x18 powers it down. Status bit 1 shows the powered state once busy clears.
- R5: Command 0x11 (array read) senses the physical row given by address bits [6:0]. The 32-bit result is readable at 0x00C once busy clears.
- R6: Command 0x12 (margin read) senses the same row with the margin pin asserted. The margin result is readable at 0x00C once busy clears.
- R7: Command 0x14 (program) sets exactly one fuse bit. Address bits [11:7] give the bit index, bits [6:1] the logical word and bit 0 the row, so bits [6:0] form the physical row. Sense and program pins are never active together.
- R8: While the macro is powered down, array read, margin read and program commands are ignored. Busy stays low and read data is unchanged.
- R9: Command 0x30 (bit 5 set) performs a refresh. It powers the macro, senses all 2*WORDS rows, writes shadow word w as row 2w OR row 2w+1, and keeps busy high for 2*WORDS*OP_CYCLES cycles. It leaves the macro powered down.
- R10: Shadow word w is read at offset 0x100+4w. Reads in the shadow range that are not word-aligned return 0. Bus writes to the shadow range change nothing.
- R11: Writing 1 to bit 0 of offset 0x014 sets a lock that reads back as 1 and stays set until reset. Program commands are ignored while it is set.
- R12: When several operation bits are written together with the strobe, one operation runs, chosen in this order: refresh (bit 5), program (bit 2), margin read (bit 1), array read (bit 0), power-down (bit 3), power-up (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | BUS_AW (9) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| fuse_pwr | output | 1 | Macro power enable |
| fuse_rd | output | 1 | Macro sense enable |
| fuse_margin | output | 1 | Margin sense select |
| fuse_prg | output | 1 | One-cycle program pulse |
| fuse_addr | output | PA_W (7) | Physical row |
| fuse_bit | output | BIT_W (5) | Bit index to program |
| fuse_rdata | input | DATA_W (32) | Sensed row data from the macro |

## Verification
A wrong operation timer shows directly as a busy window at status bit 0 that is longer or shorter than OP_CYCLES, on the first command after reset. A wrong address split or bit index shows as the wrong bit set in the very next array read of the programmed row. A refresh sequencer that skips or misorders rows shows up in the shadow sweep that follows it, as soon as one word differs from the OR of its two rows. A stale power or lock state shows within one cycle: busy rises where it must not, or the read data changes.

// File: rtl/efc_pkg.sv
`timescale 1ns/1ps
package efc_pkg;

  localparam int OFF_MODE    = 'h000;
  localparam int OFF_ADDR    = 'h004;
  localparam int OFF_RDAT    = 'h00C;
  localparam int OFF_STAT    = 'h010;
  localparam int OFF_LOCK    = 'h014;
  localparam int SHADOW_BASE = 'h100;

  localparam int MB_ARD = 0;
  localparam int MB_MRD = 1;
  localparam int MB_PRG = 2;
  localparam int MB_PDN = 3;
  localparam int MB_GO  = 4;
  localparam int MB_REF = 5;

  typedef enum logic [2:0] {
    OP_PWRUP, OP_PWRDN, OP_ARD, OP_MRD, OP_PRG, OP_REF
  } efc_op_e;

  // Priority: refresh, program, margin read, array read, power-down, power-up
  function automatic efc_op_e decode_op(input logic [5:0] m);
    if (m[MB_REF])      return OP_REF;
    else if (m[MB_PRG]) return OP_PRG;
    else if (m[MB_MRD]) return OP_MRD;
    else if (m[MB_ARD]) return OP_ARD;
    else if (m[MB_PDN]) return OP_PWRDN;
    else                return OP_PWRUP;
  endfunction

endpackage

// File: rtl/efc_shadow.sv
`timescale 1ns/1ps
module efc_shadow #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] bank [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                          bank[g] <= '0;
      else if (we && widx == IDX_W'(g))    bank[g] <= wdata;
    end
  end

  assign rdata = bank[ridx];

endmodule

// File: rtl/efc_seq.sv
`timescale 1ns/1ps
module efc_seq
  import efc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORDS     = 64,
  parameter int OP_CYCLES = 4,
  localparam int ROWS   = 2 * WORDS,
  localparam int PA_W   = $clog2(ROWS),
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int AREG_W = PA_W + BIT_W,
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  efc_op_e           op,
  input  logic [AREG_W-1:0] areg,
  output logic              busy,
  output logic              pwr,
  output logic              m_rd,
  output logic              m_margin,
  output logic              m_prg,
  output logic [PA_W-1:0]   m_addr,
  output logic [BIT_W-1:0]  m_bit,
  input  logic [DATA_W-1:0] m_rdata,
  output logic [DATA_W-1:0] rd_q,
  output logic              sh_we,
  output logic [IDX_W-1:0]  sh_idx,
  output logic [DATA_W-1:0] sh_data
);

  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_REF} st_e;

  st_e               st;
  efc_op_e           op_q;
  logic [AREG_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt;
  logic [PA_W-1:0]   row_q;
  logic [DATA_W-1:0] acc;
  logic              last;

  assign last = (cnt == CNT_W'(OP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= OP_PWRUP;
      addr_q <= '0;
      cnt    <= '0;
      row_q  <= '0;
      acc    <= '0;
      pwr    <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= areg;
          cnt    <= '0;
          row_q  <= '0;
          if (op == OP_REF) begin
            st  <= ST_REF;
            pwr <= 1'b1;
          end else begin
            st <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last) begin
            cnt <= '0;
            st  <= ST_IDLE;
            case (op_q)
              OP_ARD, OP_MRD: rd_q <= m_rdata;
              OP_PWRUP:       pwr  <= 1'b1;
              OP_PWRDN:       pwr  <= 1'b0;
              default:        ;
            endcase
          end
        end
        ST_REF: begin
          cnt <= cnt + 1'b1;
          if (last) begin
            cnt   <= '0;
            row_q <= row_q + 1'b1;
            if (!row_q[0]) acc <= m_rdata;
            if (row_q == PA_W'(ROWS - 1)) begin
              st  <= ST_IDLE;
              pwr <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign m_rd     = (st == ST_REF) || (st == ST_RUN && (op_q == OP_ARD || op_q == OP_MRD));
  assign m_margin = (st == ST_RUN) && (op_q == OP_MRD);
  assign m_prg    = (st == ST_RUN) && (op_q == OP_PRG) && last;
  assign m_addr   = (st == ST_REF) ? row_q : addr_q[PA_W-1:0];
  assign m_bit    = addr_q[PA_W +: BIT_W];

  assign sh_we   = (st == ST_REF) && last && row_q[0];
  assign sh_idx  = row_q[PA_W-1:1];
  assign sh_data = acc | m_rdata;

endmodule

// File: rtl/efuse_ctrl.sv
`timescale 1ns/1ps
module efuse_ctrl
  import efc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORDS     = 64,
  parameter int OP_CYCLES = 4,
  localparam int ROWS   = 2 * WORDS,
  localparam int PA_W   = $clog2(ROWS),
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int BUS_AW = $clog2(SHADOW_BASE + 4 * WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fuse_pwr,
  output logic              fuse_rd,
  output logic              fuse_margin,
  output logic              fuse_prg,
  output logic [PA_W-1:0]   fuse_addr,
  output logic [BIT_W-1:0]  fuse_bit,
  input  logic [DATA_W-1:0] fuse_rdata
);

  localparam int AREG_W = PA_W + BIT_W;
  localparam int IDX_W  = $clog2(WORDS);

  logic [5:0]        mode_q;
  logic [AREG_W-1:0] addr_q;
  logic              lock_q;
  logic              busy;
  logic              wr_en;
  logic              go;
  logic              start;
  efc_op_e           op;
  logic [DATA_W-1:0] rd_q;
  logic              sh_we;
  logic [IDX_W-1:0]  sh_widx;
  logic [DATA_W-1:0] sh_wdata;
  logic [DATA_W-1:0] sh_rdata;
  logic [BUS_AW-1:0] sh_off;
  logic              in_sh;

  assign wr_en = bus_sel && bus_wr && !busy;
  assign go    = wr_en && (bus_addr == BUS_AW'(OFF_MODE)) && bus_wdata[MB_GO];
  assign op    = decode_op(bus_wdata[5:0]);

  always_comb begin
    start = 1'b0;
    if (go) begin
      case (op)
        OP_REF, OP_PWRUP, OP_PWRDN: start = 1'b1;
        OP_PRG:                     start = fuse_pwr && !lock_q;
        default:                    start = fuse_pwr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      addr_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      if (bus_addr == BUS_AW'(OFF_MODE)) mode_q <= bus_wdata[5:0] & ~6'(1 << MB_GO);
      if (bus_addr == BUS_AW'(OFF_ADDR)) addr_q <= bus_wdata[AREG_W-1:0];
      if (bus_addr == BUS_AW'(OFF_LOCK) && bus_wdata[0]) lock_q <= 1'b1;
    end
  end

  efc_seq #(.DATA_W(DATA_W), .WORDS(WORDS), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .areg     (addr_q),
    .busy     (busy),
    .pwr      (fuse_pwr),
    .m_rd     (fuse_rd),
    .m_margin (fuse_margin),
    .m_prg    (fuse_prg),
    .m_addr   (fuse_addr),
    .m_bit    (fuse_bit),
    .m_rdata  (fuse_rdata),
    .rd_q     (rd_q),
    .sh_we    (sh_we),
    .sh_idx   (sh_widx),
    .sh_data  (sh_wdata)
  );

  assign sh_off = bus_addr - BUS_AW'(SHADOW_BASE);
  assign in_sh  = (int'(bus_addr) >= SHADOW_BASE) && (int'(sh_off) < 4 * WORDS);

  efc_shadow #(.DATA_W(DATA_W), .WORDS(WORDS)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sh_we),
    .widx  (sh_widx),
    .wdata (sh_wdata),
    .ridx  (sh_off[IDX_W+1:2]),
    .rdata (sh_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_sh) begin
      if (bus_addr[1:0] == 2'b00) bus_rdata = sh_rdata;
    end else begin
      case (int'(bus_addr))
        OFF_MODE: bus_rdata = DATA_W'(mode_q);
        OFF_ADDR: bus_rdata = DATA_W'(addr_q);
        OFF_RDAT: bus_rdata = rd_q;
        OFF_STAT: bus_rdata = DATA_W'({fuse_pwr, busy});
        OFF_LOCK: bus_rdata = DATA_W'(lock_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/efc_checker.sv
`timescale 1ns/1ps
module efc_checker #(
  parameter int AREG_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              busy,
  input logic [5:0]        mode_q,
  input logic [AREG_W-1:0] addr_q,
  input logic              lock_q,
  input logic              fuse_pwr,
  input logic              fuse_rd,
  input logic              fuse_prg,
  input logic              sh_we
);

  AST_BUSY_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && bus_wr) |=> ($stable(mode_q) && $stable(addr_q) && $stable(lock_q))); // R3

  AST_PRG_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prg |-> fuse_pwr); // R8

  AST_PRG_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prg |-> !lock_q); // R11

  AST_SENSE_PRG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fuse_rd, fuse_prg})); // R7

  AST_SHADOW_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    sh_we |-> (busy && fuse_pwr && fuse_rd)); // R9

  AST_PWR_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_pwr) |-> $fell(busy)); // R9

endmodule

bind efuse_ctrl efc_checker #(.AREG_W(AREG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .busy     (busy),
  .mode_q   (mode_q),
  .addr_q   (addr_q),
  .lock_q   (lock_q),
  .fuse_pwr (fuse_pwr),
  .fuse_rd  (fuse_rd),
  .fuse_prg (fuse_prg),
  .sh_we    (sh_we)
);

// File: tb/tb_efuse_ctrl.sv
`timescale 1ns/1ps
module tb_efuse_ctrl;

  localparam int NCYC  = 4;
  localparam int WORDS = 64;
  localparam int ROWS  = 2 * WORDS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fuse_pwr, fuse_rd, fuse_margin, fuse_prg;
  logic [6:0]  fuse_addr;
  logic [4:0]  fuse_bit;
  logic [31:0] fuse_rdata;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] phys [ROWS];
  logic [31:0] expv [ROWS];

  always #4 clk = ~clk;

  efuse_ctrl #(.DATA_W(32), .WORDS(WORDS), .OP_CYCLES(NCYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_pwr(fuse_pwr), .fuse_rd(fuse_rd), .fuse_margin(fuse_margin),
    .fuse_prg(fuse_prg), .fuse_addr(fuse_addr), .fuse_bit(fuse_bit),
    .fuse_rdata(fuse_rdata)
  );

  function automatic logic [31:0] seed_word(int r);
    return (32'(r) * 32'h2545F491) ^ 32'hA500_3C00;
  endfunction

  function automatic logic [31:0] weak_mask(int r);
    return (32'h1 << (r % 32)) | (32'h8000_0000 >> (r % 7));
  endfunction

  // Behavioural fuse macro
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) phys[r] <= seed_word(r);
    end else if (fuse_prg && fuse_pwr) begin
      phys[fuse_addr][fuse_bit] <= 1'b1;
    end
  end

  assign fuse_rdata = !fuse_pwr ? 32'h0 :
                      fuse_margin ? (phys[fuse_addr] & ~weak_mask(int'(fuse_addr))) :
                      phys[fuse_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 9'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    rd('h10, s);
    while (s[0]) begin
      @(negedge clk);
      rd('h10, s);
    end
  endtask

  task automatic count_busy(output int n);
    logic [31:0] s;
    n = 0;
    rd('h10, s);
    while (s[0]) begin
      n++;
      @(negedge clk);
      rd('h10, s);
    end
  endtask

  task automatic cmd(input logic [31:0] m);
    wr('h0, m);
    wait_idle();
  endtask

  task automatic array_read(input int row, output logic [31:0] d);
    wr('h4, 32'(row));
    cmd(32'h11);
    rd('hC, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] d, prev;
    int n;
    int zb;
    for (int r = 0; r < ROWS; r++) expv[r] = seed_word(r);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd('h10, d); chk(d == 0, "R1 status", d, 0);
    rd('hC, d);  chk(d == 0, "R1 rddata", d, 0);
    rd('h0, d);  chk(d == 0, "R1 mode", d, 0);
    for (int w = 0; w < WORDS; w++) begin
      rd('h100 + 4 * w, d); chk(d == 0, "R1 shadow", d, 0);
    end

    // R8 read while powered down is ignored
    wr('h4, 32'd5);
    wr('h0, 32'h11);
    rd('h10, d); chk(d[0] == 0, "R8 no busy when off", d, 0);
    rd('hC, d);  chk(d == 0, "R8 rddata unchanged", d, 0);

    // R2 / R4 power up
    wr('h0, 32'h10);
    count_busy(n);
    chk(n == NCYC, "R2 busy length", 32'(n), 32'(NCYC));
    rd('h0, d);  chk(d == 0, "R2 strobe self-clear", d, 0);
    rd('h10, d); chk(d == 32'h2, "R4 powered", d, 32'h2);

    // R5 array read sweep of every physical row
    for (int r = 0; r < ROWS; r++) begin
      array_read(r, d);
      chk(d == expv[r], "R5 array read", d, expv[r]);
    end
    rd('h0, d); chk(d == 32'h1, "R2 mode readback", d, 32'h1);

    // R6 margin read sweep
    for (int r = 0; r < ROWS; r++) begin
      wr('h4, 32'(r));
      wr('h0, 32'h12);
      count_busy(n);
      if (r == 0) chk(n == NCYC, "R2 margin busy length", 32'(n), 32'(NCYC));
      rd('hC, d);
      chk(d == (expv[r] & ~weak_mask(r)), "R6 margin read", d, expv[r] & ~weak_mask(r));
    end

    // R3 writes while busy are ignored
    wr('h4, 32'd3);
    wr('h0, 32'h11);
    wr('h4, 32'h7F);
    wr('h0, 32'h12);
    wait_idle();
    rd('h4, d);  chk(d == 3, "R3 addr held", d, 3);
    rd('h0, d);  chk(d == 32'h1, "R3 mode held", d, 32'h1);
    rd('hC, d);  chk(d == expv[3], "R3 first op result", d, expv[3]);
    @(negedge clk);
    rd('h10, d); chk(d[0] == 0, "R3 no second op", d, 0);

    // R7 program one bit per position
    for (int k = 0; k < 32; k++) begin
      int row;
      row = (k * 5 + 1) % ROWS;
      wr('h4, (32'(k) << 7) | 32'(row));
      wr('h0, 32'h14);
      count_busy(n);
      if (k == 0) chk(n == NCYC, "R2 program busy length", 32'(n), 32'(NCYC));
      expv[row][k] = 1'b1;
      array_read(row, d);
      chk(d == expv[row], "R7 program bit", d, expv[row]);
    end

    // R12 priority: program beats both reads
    array_read(20, prev);
    wr('h4, (32'd30 << 7) | 32'd21);
    cmd(32'h17);
    expv[21][30] = 1'b1;
    rd('hC, d); chk(d == prev, "R12 program wins over reads", d, prev);
    array_read(21, d); chk(d == expv[21], "R12 program applied", d, expv[21]);
    // margin beats array
    wr('h4, 32'd40);
    cmd(32'h13);
    rd('hC, d); chk(d == (expv[40] & ~weak_mask(40)), "R12 margin wins", d, expv[40] & ~weak_mask(40));
    // array beats power-down
    wr('h4, 32'd41);
    cmd(32'h19);
    rd('hC, d);  chk(d == expv[41], "R12 array wins", d, expv[41]);
    rd('h10, d); chk(d == 32'h2, "R12 still powered", d, 32'h2);

    // R11 lock blocks programming
    wr('h14, 32'h1);
    rd('h14, d); chk(d == 1, "R11 lock readback", d, 1);
    wr('h14, 32'h0);
    rd('h14, d); chk(d == 1, "R11 lock sticky", d, 1);
    zb = 0;
    for (int b = 31; b >= 0; b--) if (!expv[100][b]) zb = b;
    wr('h4, (32'(zb) << 7) | 32'd100);
    wr('h0, 32'h14);
    rd('h10, d); chk(d[0] == 0, "R11 program ignored", d, 0);
    array_read(100, d); chk(d == expv[100], "R11 row unchanged", d, expv[100]);

    // R9 refresh
    wr('h0, 32'h30);
    count_busy(n);
    chk(n == ROWS * NCYC, "R9 refresh length", 32'(n), 32'(ROWS * NCYC));
    rd('h10, d); chk(d == 0, "R9 auto power-down", d, 0);
    for (int w = 0; w < WORDS; w++) begin
      rd('h100 + 4 * w, d);
      chk(d == (expv[2*w] | expv[2*w+1]), "R9 R10 shadow word", d, expv[2*w] | expv[2*w+1]);
    end

    // R10 misaligned and write-protected shadow
    rd('h101, d); chk(d == 0, "R10 misaligned", d, 0);
    rd('h1FE, d); chk(d == 0, "R10 misaligned top", d, 0);
    wr('h104, 32'hFFFF_FFFF);
    rd('h104, d); chk(d == (expv[2] | expv[3]), "R10 shadow read-only", d, expv[2] | expv[3]);

    // R8 after refresh: macro is off, reads ignored
    rd('hC, prev);
    wr('h4, 32'd7);
    wr('h0, 32'h12);
    rd('h10, d); chk(d[0] == 0, "R8 margin ignored when off", d, 0);
    rd('hC, d);  chk(d == prev, "R8 rddata held", d, prev);

    // R4 power up then down
    cmd(32'h10);
    rd('h10, d); chk(d == 32'h2, "R4 up", d, 32'h2);
    wr('h0, 32'h18);
    count_busy(n);
    chk(n == NCYC, "R2 power-down length", 32'(n), 32'(NCYC));
    rd('h10, d); chk(d == 0, "R4 down", d, 0);

    finish_run();
  end

endmodule